// File: doc/BRIEF.md
# Legacy Prefix Scanner

This block sits at the front of an x86 instruction decoder and consumes the instruction stream one byte per cycle. It absorbs the legacy prefix bytes and, when the core runs in 64-bit mode, the register-extension prefix (bytes 0x40 to 0x4F). It keeps a running picture of what those prefixes select. When the first opcode byte arrives, it reports that byte together with the collected attributes. The escape byte 0x0F is handled as a marker that the following byte belongs to the second opcode map.

A single-cycle strobe carries the opcode byte and every attribute. The scanner then clears its state, so the next byte begins a new instruction. The hard limit of 15 bytes per instruction is enforced. If a 16th byte arrives while the scanner is still collecting, that byte is dropped, a fault pulse is raised, and scanning restarts at the next byte. Decoding of ModR/M, SIB, displacement and immediate bytes is left to later stages.

Top module: `legacy_prefix_scanner`

## Requirements
- R1: Segment prefixes set `seg_sel`: 0x26→1, 0x2E→2, 0x36→3, 0x3E→4, 0x64→5, 0x65→6, and 0 when no segment prefix is present. When several segment prefixes appear, the last one determines the value.
- R2: Byte 0xF0 sets `lock` for the instruction.
- R3: `rep_kind` is 0 with no repeat prefix, 1 for 0xF2 and 2 for 0xF3. When both appear, the later one decides.
- R4: Byte 0x66 sets `opsize_ovr` and byte 0x67 sets `adsize_ovr`. Each flag records presence, so a repeated byte keeps the flag set.
- R5: After byte 0x0F, the next byte is reported as the opcode with `escape`=1, whatever its value, including values that would otherwise be prefixes. The byte 0x0F is not counted in `pfx_count`.
- R6: When `mode64`=1, a byte 0x4X before the opcode or escape is a prefix. Its bit 3 goes to `ext_w`, bit 2 to `ext_r`, bit 1 to `ext_x` and bit 0 to `ext_b`. The byte 0x40 is still counted in `pfx_count` while setting no bits.
- R7: When `mode64`=0, a byte 0x4X is reported as the opcode, with `escape`=0 and all four extension bits at 0.
- R8: The extension bits apply only when their prefix is the last prefix before the opcode or escape byte. Any legacy prefix that follows it clears them. A later extension prefix replaces an earlier one.
- R9: `opcode_valid` is high for exactly one cycle, the cycle after the opcode byte is accepted, and carries `pfx_count` (the number of prefix bytes). No strobe is produced for prefix or escape bytes. Idle cycles (`byte_valid`=0) hold the collected state. After a strobe, the next instruction starts with all attributes cleared.
- R10: An instruction of exactly 15 bytes completes normally. If a 16th byte arrives while collecting, `len_fault` pulses for one cycle, in the cycle after that byte. There is no strobe, the byte is dropped, and the next byte starts a new instruction.
- R11: After reset, `opcode_valid`, `len_fault` and every attribute output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode64 | input | 1 | 1 selects 64-bit mode (0x4X are prefixes) |
| byte_valid | input | 1 | `byte_in` holds a stream byte this cycle |
| byte_in | input | 8 | Instruction stream byte |
| opcode_valid | output | 1 | One-cycle strobe: opcode and attributes valid |
| opcode | output | 8 | First opcode byte |
| escape | output | 1 | Opcode comes from the second map |
| pfx_count | output | CW | Number of prefix bytes before the opcode |
| seg_sel | output | 3 | Segment override code |
| lock | output | 1 | Lock prefix present |
| rep_kind | output | 2 | Repeat kind |
| opsize_ovr | output | 1 | Operand-size toggle present |
| adsize_ovr | output | 1 | Address-size toggle present |
| ext_w | output | 1 | Extension prefix: 64-bit data |
| ext_r | output | 1 | Extension prefix: reg field bit |
| ext_x | output | 1 | Extension prefix: index field bit |
| ext_b | output | 1 | Extension prefix: base/rm field bit |
| len_fault | output | 1 | One-cycle pulse: instruction exceeded 15 bytes |

## Verification
Both results are registered once. The strobe and its attributes appear on the clock edge that accepts the opcode byte. The fault pulse appears on the edge that accepts the 16th byte. The bench drives bytes on falling edges, and its monitor samples on the following falling edge, which is half a cycle after the result becomes visible. Expectations are queued in stream order before their bytes are sent. Any strobe or fault that arrives with nothing queued is counted as a failure, as is any expectation still waiting at the end. Idle gaps inside an instruction confirm that results shift only with accepted bytes.

// File: rtl/legacy_prefix_scanner.sv
module legacy_prefix_scanner #(
  parameter int MAX_LEN = 15,
  localparam int CW = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode64,
  input  logic          byte_valid,
  input  logic [7:0]    byte_in,
  output logic          opcode_valid,
  output logic [7:0]    opcode,
  output logic          escape,
  output logic [CW-1:0] pfx_count,
  output logic [2:0]    seg_sel,
  output logic          lock,
  output logic [1:0]    rep_kind,
  output logic          opsize_ovr,
  output logic          adsize_ovr,
  output logic          ext_w,
  output logic          ext_r,
  output logic          ext_x,
  output logic          ext_b,
  output logic          len_fault
);

  localparam logic [CW-1:0] LIMIT = CW'(MAX_LEN);

  logic [CW-1:0] len_q, pcnt_q;
  logic          esc_q, lock_q, os_q, as_q;
  logic [2:0]    seg_q;
  logic [1:0]    rep_q;
  logic [3:0]    ext_q;

  logic [2:0] seg_code;
  always_comb begin
    case (byte_in)
      8'h26:   seg_code = 3'd1;
      8'h2E:   seg_code = 3'd2;
      8'h36:   seg_code = 3'd3;
      8'h3E:   seg_code = 3'd4;
      8'h64:   seg_code = 3'd5;
      8'h65:   seg_code = 3'd6;
      default: seg_code = 3'd0;
    endcase
  end

  wire is_lock   = byte_in == 8'hF0;
  wire is_repne  = byte_in == 8'hF2;
  wire is_rep    = byte_in == 8'hF3;
  wire is_os     = byte_in == 8'h66;
  wire is_as     = byte_in == 8'h67;
  wire is_esc    = byte_in == 8'h0F;
  wire is_legacy = (seg_code != 3'd0) | is_lock | is_repne | is_rep | is_os | is_as;
  wire is_ext    = mode64 & (byte_in[7:4] == 4'h4);
  wire at_limit  = len_q == LIMIT;
  wire take_op   = byte_valid & ~at_limit & (esc_q | (~is_legacy & ~is_ext & ~is_esc));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0; pcnt_q <= '0; esc_q <= 1'b0; lock_q <= 1'b0;
      os_q <= 1'b0; as_q <= 1'b0; seg_q <= '0; rep_q <= '0; ext_q <= '0;
      opcode_valid <= 1'b0; opcode <= '0; escape <= 1'b0; pfx_count <= '0;
      seg_sel <= '0; lock <= 1'b0; rep_kind <= '0; opsize_ovr <= 1'b0;
      adsize_ovr <= 1'b0; {ext_w, ext_r, ext_x, ext_b} <= '0; len_fault <= 1'b0;
    end else begin
      opcode_valid <= 1'b0;
      len_fault    <= 1'b0;
      if (byte_valid) begin
        if (at_limit || take_op) begin
          if (at_limit) begin
            len_fault <= 1'b1;
          end else begin
            opcode_valid <= 1'b1;
            opcode       <= byte_in;
            escape       <= esc_q;
            pfx_count    <= pcnt_q;
            seg_sel      <= seg_q;
            lock         <= lock_q;
            rep_kind     <= rep_q;
            opsize_ovr   <= os_q;
            adsize_ovr   <= as_q;
            {ext_w, ext_r, ext_x, ext_b} <= ext_q;
          end
          len_q <= '0; pcnt_q <= '0; esc_q <= 1'b0; lock_q <= 1'b0;
          os_q <= 1'b0; as_q <= 1'b0; seg_q <= '0; rep_q <= '0; ext_q <= '0;
        end else begin
          len_q <= len_q + 1'b1;
          if (is_esc) begin
            esc_q <= 1'b1;
          end else if (is_legacy) begin
            pcnt_q <= pcnt_q + 1'b1;
            ext_q  <= '0;
            if (seg_code != 3'd0) seg_q <= seg_code;
            if (is_lock)  lock_q <= 1'b1;
            if (is_repne) rep_q  <= 2'd1;
            if (is_rep)   rep_q  <= 2'd2;
            if (is_os)    os_q   <= 1'b1;
            if (is_as)    as_q   <= 1'b1;
          end else begin
            pcnt_q <= pcnt_q + 1'b1;
            ext_q  <= byte_in[3:0];
          end
        end
      end
    end
  end

  AST_STROBE_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(opcode_valid && len_fault)); // R9
  AST_FAULT_ON_EXTRA_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    len_fault |-> $past(rst_n) && $past(byte_valid) && $past(len_q) == LIMIT); // R10
  AST_PFX_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    opcode_valid |-> pfx_count < LIMIT); // R10
  AST_ESC_NEXT_IS_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(byte_valid) && $past(esc_q) && $past(len_q) != LIMIT
    |-> opcode_valid && escape && opcode == $past(byte_in)); // R5
  AST_LEGACY32_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(byte_valid) && !$past(mode64) && !$past(esc_q)
    && $past(byte_in[7:4]) == 4'h4 && $past(len_q) != LIMIT
    |-> opcode_valid && !ext_w && !ext_r && !ext_x && !ext_b); // R7

endmodule

// File: tb/legacy_prefix_scanner_test.sv
module legacy_prefix_scanner_test;
  localparam int CW = 4;

  logic clk = 1'b0, rst_n = 1'b0, mode64 = 1'b0, byte_valid = 1'b0;
  logic [7:0] byte_in = '0;
  logic opcode_valid, escape, lock, opsize_ovr, adsize_ovr;
  logic ext_w, ext_r, ext_x, ext_b, len_fault;
  logic [7:0] opcode;
  logic [CW-1:0] pfx_count;
  logic [2:0] seg_sel;
  logic [1:0] rep_kind;

  always #5 clk = ~clk;

  legacy_prefix_scanner uut (.clk, .rst_n, .mode64, .byte_valid, .byte_in,
    .opcode_valid, .opcode, .escape, .pfx_count, .seg_sel, .lock, .rep_kind,
    .opsize_ovr, .adsize_ovr, .ext_w, .ext_r, .ext_x, .ext_b, .len_fault);

  typedef struct packed {
    logic flt; logic [7:0] op; logic esc; logic [3:0] pc; logic [2:0] seg;
    logic lk; logic [1:0] rp; logic os; logic as_; logic [3:0] ext;
  } item_t;

  item_t exp_q[$];
  string tag_q[$];
  int checks = 0, fails = 0;

  function automatic item_t mk(logic [7:0] op, logic esc, logic [3:0] pc, logic [2:0] seg,
                               logic lk, logic [1:0] rp, logic os, logic as_, logic [3:0] ext);
    return '{flt: 1'b0, op: op, esc: esc, pc: pc, seg: seg, lk: lk, rp: rp, os: os, as_: as_, ext: ext};
  endfunction

  task automatic expect_item(item_t it, string tag);
    exp_q.push_back(it);
    tag_q.push_back(tag);
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    byte_valid = 1'b1;
    byte_in = b;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      byte_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (opcode_valid || len_fault)) begin
      item_t got, ex;
      string tg;
      got = '{flt: len_fault, op: opcode, esc: escape, pc: pfx_count, seg: seg_sel, lk: lock,
              rp: rep_kind, os: opsize_ovr, as_: adsize_ovr, ext: {ext_w, ext_r, ext_x, ext_b}};
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R9 unexpected result: got %h expected none", got);
      end else begin
        ex = exp_q.pop_front();
        tg = tag_q.pop_front();
        if (ex.flt ? !got.flt : got != ex) begin
          fails++;
          $display("FAIL %s: got %h expected %h", tg, got, ex);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({opcode_valid, len_fault, opcode, escape, pfx_count, seg_sel, lock, rep_kind,
         opsize_ovr, adsize_ovr, ext_w, ext_r, ext_x, ext_b} != '0) begin
      fails++;
      $display("FAIL R11 reset state: got nonzero expected all zero");
    end

    // 32-bit mode
    expect_item(mk(8'h90, 0, 0, 0, 0, 0, 0, 0, 0), "R9 bare opcode");
    send(8'h90);
    expect_item(mk(8'h8B, 0, 3, 4, 0, 0, 0, 0, 0), "R1 last segment DS");
    send(8'h26); send(8'h2E); send(8'h3E); send(8'h8B);
    expect_item(mk(8'h8B, 0, 2, 6, 0, 0, 0, 0, 0), "R1 FS then GS");
    send(8'h64); send(8'h65); send(8'h8B);
    expect_item(mk(8'hA4, 0, 3, 0, 1, 1, 0, 0, 0), "R2 R3 lock and REPNE last");
    send(8'hF0); send(8'hF3); send(8'hF2); send(8'hA4);
    expect_item(mk(8'hAA, 0, 2, 0, 0, 2, 0, 0, 0), "R3 REP last");
    send(8'hF2); send(8'hF3); send(8'hAA);
    expect_item(mk(8'h89, 0, 3, 0, 0, 0, 1, 1, 0), "R4 size toggles");
    send(8'h66); send(8'h67); send(8'h66); send(8'h89);
    expect_item(mk(8'h26, 1, 0, 0, 0, 0, 0, 0, 0), "R5 escape with prefix value");
    send(8'h0F); send(8'h26);
    expect_item(mk(8'h3A, 1, 1, 0, 0, 0, 1, 0, 0), "R5 prefix then escape");
    send(8'h66); send(8'h0F); send(8'h3A);
    expect_item(mk(8'h48, 0, 0, 0, 0, 0, 0, 0, 0), "R7 0x48 as opcode");
    send(8'h48);
    expect_item(mk(8'h41, 0, 1, 0, 0, 0, 1, 0, 0), "R7 0x41 after prefix");
    send(8'h66); send(8'h41);
    expect_item(mk(8'h90, 0, 1, 2, 0, 0, 0, 0, 0), "R9 gap holds state");
    send(8'h2E); idle(3); send(8'h90);
    idle(2);

    // 64-bit mode
    mode64 = 1'b1;
    expect_item(mk(8'h89, 0, 1, 0, 0, 0, 0, 0, 4'h8), "R6 W bit");
    send(8'h48); send(8'h89);
    expect_item(mk(8'hB6, 1, 1, 0, 0, 0, 0, 0, 4'hF), "R6 all bits with escape");
    send(8'h4F); send(8'h0F); send(8'hB6);
    expect_item(mk(8'hC3, 0, 1, 0, 0, 0, 0, 0, 4'h0), "R6 empty 0x40 counted");
    send(8'h40); send(8'hC3);
    expect_item(mk(8'h89, 0, 2, 0, 0, 0, 1, 0, 4'h0), "R8 legacy after ext clears");
    send(8'h48); send(8'h66); send(8'h89);
    expect_item(mk(8'h8B, 0, 2, 0, 0, 0, 0, 0, 4'hC), "R8 later ext replaces");
    send(8'h41); send(8'h4C); send(8'h8B);
    expect_item(mk(8'h8B, 0, 2, 3, 0, 0, 0, 0, 4'h5), "R1 R6 segment then ext");
    send(8'h36); send(8'h45); send(8'h8B);
    expect_item(mk(8'h90, 0, 0, 0, 0, 0, 0, 0, 0), "R9 clean after previous");
    send(8'h90);

    // length limit
    expect_item('{flt: 1'b1, default: '0}, "R10 escape pushes to 16th byte");
    for (int i = 0; i < 14; i++) send(8'h66);
    send(8'h0F); send(8'h05);
    expect_item(mk(8'h90, 0, 0, 0, 0, 0, 0, 0, 0), "R10 restart after fault");
    send(8'h90);
    expect_item(mk(8'h90, 0, 14, 0, 0, 2, 0, 0, 0), "R10 15-byte instruction ok");
    for (int i = 0; i < 14; i++) send(8'hF3);
    send(8'h90);
    expect_item('{flt: 1'b1, default: '0}, "R10 15 prefixes then opcode");
    for (int i = 0; i < 15; i++) send(8'hF0);
    send(8'h90);
    expect_item(mk(8'hC3, 0, 0, 0, 0, 0, 0, 0, 0), "R10 no leftover after fault");
    send(8'hC3);
    idle(5);

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R9 missing results: got %0d pending expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule